// File: doc/BRIEF.md
# Three-Pin Mixed-Signal General-Purpose Port

This block is a three-bit general-purpose I/O port. Each pin can also carry an analog converter input, or a control strobe for a parallel slave interface. The port holds a data latch and a direction latch. A CPU reaches both latches over a small register bus, with one address bit for data and one for direction. The port drives an output enable and an output level for each pin toward the pads. On a data read it returns, for each pin, the synchronized pad level or the latch contents.

A separate configuration block supplies a per-pin analog-select vector. The digital view of an analog pin always reads zero. The direction latch still governs that pin's driver, so software must keep analog pins configured as inputs.

A slave-mode input turns the three pins into strobe inputs for a parallel slave interface. In that mode every driver is switched off, and the synchronized pin levels are sent to three dedicated strobe outputs. The pad buffers, the converter and the analog-select decode lie outside the block.

Top module: `mixport3`

## Requirements
- R1: Register address 0 selects the data register and address 1 selects the direction register. A write happens on a clock edge with busSel=1 and busWrite=1. When busSel=1 and busWrite=0, busRdata shows the addressed register without delay. Otherwise busRdata is 0, and nothing is written while busSel=0.
- R2: Each pin's direction is set on its own by bit i of the direction register. A value of 1 makes the pin an input, with padOe[i]=0. A value of 0 makes it an output, with padOe[i]=1 and padOut[i] equal to data latch bit i.
- R3: On a data register read, a pin with analogSel[i]=1 returns 0.
- R4: For a pin with analogSel[i]=1, padOe[i] still follows its direction bit.
- R5: After reset the direction register reads 3'b111, the data latch reads 0 and the synchronizers hold 0. A data read straight after reset therefore returns 3'b000.
- R6: While slaveMode=1, padOe is 3'b000. In that mode slvRead, slvWrite and slvSelect carry the synchronized levels of pins 0, 1 and 2. While slaveMode=0 these three outputs are 0.
- R7: A data register write updates the latch whatever the direction. The latch value reaches the pad only on output pins. A data read of a digital output pin returns the latch bit.
- R8: A data read of a digital input pin returns the pad level through a two-flop synchronizer. A pad change made between clock edges becomes visible after the second following rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access select |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 1 | 0 = data register, 1 = direction register |
| busWdata | input | 3 | Write data |
| busRdata | output | 3 | Read data, combinational |
| padIn | input | 3 | Levels seen at the pads |
| padOut | output | 3 | Output levels toward the pads |
| padOe | output | 3 | Output enables toward the pads |
| analogSel | input | 3 | Per-pin analog selection |
| slaveMode | input | 1 | Pins act as slave-port strobes |
| slvRead | output | 1 | Synchronized pin 0 in slave mode |
| slvWrite | output | 1 | Synchronized pin 1 in slave mode |
| slvSelect | output | 1 | Synchronized pin 2 in slave mode |

## Verification
The port read path is tried with mixed direction vectors such as 3'b010, so that latch bits and pad bits appear in the same read word. Latch value and pad value are set to differ, so a swapped source shows up as a wrong bit. Analog masks of one pin and of all pins are applied over a pad pattern of all ones, which separates masking from direction handling. Pad steps are sampled after one edge and after two edges to pin down the synchronizer depth. Slave mode is entered with every pin configured as output, which shows whether the driver override wins over the direction latch.

// File: rtl/mixport_pkg.sv
package mixport_pkg;
  localparam int PIN_COUNT = 3;
  localparam int ADDR_DATA = 0;
  localparam int ADDR_DIR  = 1;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdData;
    logic rdDir;
  } strobe_t;
endpackage

// File: rtl/mixport_ctrl.sv
module mixport_ctrl
  import mixport_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    busSel,
  input  logic    busWrite,
  input  logic    busAddr,
  output strobe_t strb
);
  logic isDir;

  always_comb begin
    isDir       = (busAddr == 1'(ADDR_DIR));
    strb.wrData = busSel &&  busWrite && !isDir;
    strb.wrDir  = busSel &&  busWrite &&  isDir;
    strb.rdData = busSel && !busWrite && !isDir;
    strb.rdDir  = busSel && !busWrite &&  isDir;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrData, strb.wrDir, strb.rdData, strb.rdDir})); // R1
endmodule

// File: rtl/mixport_datapath.sv
module mixport_datapath
  import mixport_pkg::*;
#(
  parameter int NUM_PINS    = PIN_COUNT,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] analogSel,
  input  logic                slaveMode,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] slvLines
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] dataQ;
  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] portView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '1;
    end else begin
      if (strb.wrData) dataQ <= busWdata;
      if (strb.wrDir)  dirQ  <= busWdata;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN)      syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else            syncQ[s] <= syncQ[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign pinSync = syncQ[LAST_STAGE];

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      always_comb begin
        if (analogSel[p])   portView[p] = 1'b0;
        else if (dirQ[p])   portView[p] = pinSync[p];
        else                portView[p] = dataQ[p];
        padOe[p]    = !slaveMode && !dirQ[p];
        slvLines[p] = slaveMode && pinSync[p];
      end
    end
  endgenerate

  assign padOut = dataQ;

  always_comb begin
    if (strb.rdData)     busRdata = portView;
    else if (strb.rdDir) busRdata = dirQ;
    else                 busRdata = '0;
  end

  AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> (slaveMode || padOe == ~$past(busWdata))); // R2
  AST_DATA_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> (padOut == $past(busWdata))); // R7
  AST_ANALOG_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdData |-> ((busRdata & analogSel) == '0)); // R3
  AST_SLAVE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode |-> (padOe == '0)); // R6
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdData || strb.rdDir) |-> (busRdata == '0)); // R1
  AST_STROBES_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !slaveMode |-> (slvLines == '0)); // R6
endmodule

// File: rtl/mixport3.sv
module mixport3
  import mixport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic                 busAddr,
  input  logic [PIN_COUNT-1:0] busWdata,
  output logic [PIN_COUNT-1:0] busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PIN_COUNT-1:0] analogSel,
  input  logic                 slaveMode,
  output logic                 slvRead,
  output logic                 slvWrite,
  output logic                 slvSelect
);
  strobe_t             strb;
  logic [PIN_COUNT-1:0] slvLines;

  mixport_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  mixport_datapath #(
    .NUM_PINS    (PIN_COUNT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .analogSel (analogSel),
    .slaveMode (slaveMode),
    .padOut    (padOut),
    .padOe     (padOe),
    .slvLines  (slvLines)
  );

  assign slvRead   = slvLines[0];
  assign slvWrite  = slvLines[1];
  assign slvSelect = slvLines[2];
endmodule

// File: tb/sim_mixport3.sv
`timescale 1ns/1ps
module sim_mixport3;
  logic       clk = 0;
  logic       rstN = 0;
  logic       busSel = 0, busWrite = 0, busAddr = 0;
  logic [2:0] busWdata = 0;
  logic [2:0] busRdata;
  logic [2:0] padIn = 0;
  logic [2:0] padOut, padOe;
  logic [2:0] analogSel = 0;
  logic       slaveMode = 0;
  logic       slvRead, slvWrite, slvSelect;
  int         nChecks = 0, nFails = 0;
  bit         finished = 0;

  always #4 clk = ~clk;

  mixport3 u0 (.*);

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic addr, logic [2:0] val);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = addr; busWdata = val;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic readReg(logic addr, output logic [2:0] val);
    busSel = 1; busWrite = 0; busAddr = addr;
    #1 val = busRdata;
    busSel = 0;
  endtask

  task automatic test_reset();
    logic [2:0] v;
    readReg(1, v); check("R5 dir after reset", v, 3'b111);
    readReg(0, v); check("R5 data after reset", v, 3'b000);
    check("R2 oe after reset", padOe, 3'b000);
    check("R6 strobes idle", {slvSelect, slvWrite, slvRead}, 3'b000);
    #1 check("R1 idle rdata", busRdata, 3'b000);
  endtask

  task automatic test_mixed_dir();
    logic [2:0] v;
    writeReg(1, 3'b010);
    check("R2 oe mixed", padOe, 3'b101);
    writeReg(0, 3'b111);
    check("R2 padOut", padOut, 3'b111);
    readReg(0, v); check("R7 mixed read", v, 3'b101);
  endtask

  task automatic test_latch_hidden();
    logic [2:0] v;
    writeReg(1, 3'b111);
    writeReg(0, 3'b110);
    check("R7 no drive on inputs", padOe, 3'b000);
    writeReg(1, 3'b000);
    check("R7 oe on", padOe, 3'b111);
    check("R7 latch on pad", padOut, 3'b110);
    readReg(0, v); check("R7 latch read", v, 3'b110);
  endtask

  task automatic test_sync();
    logic [2:0] v;
    writeReg(1, 3'b111);
    repeat (3) @(negedge clk);
    padIn = 3'b101;
    @(negedge clk);
    readReg(0, v); check("R8 one edge", v, 3'b000);
    @(negedge clk);
    readReg(0, v); check("R8 two edges", v, 3'b101);
  endtask

  task automatic test_analog();
    logic [2:0] v;
    padIn = 3'b111;
    repeat (3) @(negedge clk);
    analogSel = 3'b010;
    readReg(0, v); check("R3 one analog", v, 3'b101);
    analogSel = 3'b111;
    readReg(0, v); check("R3 all analog", v, 3'b000);
    writeReg(1, 3'b000);
    check("R4 analog oe", padOe, 3'b111);
    readReg(0, v); check("R3 analog output", v, 3'b000);
    analogSel = 3'b000;
  endtask

  task automatic test_slave();
    padIn = 3'b011;
    slaveMode = 1;
    #1 check("R6 oe off", padOe, 3'b000);
    repeat (2) @(negedge clk);
    check("R6 strobes", {slvSelect, slvWrite, slvRead}, 3'b011);
    padIn = 3'b100;
    repeat (2) @(negedge clk);
    check("R6 strobes swap", {slvSelect, slvWrite, slvRead}, 3'b100);
    slaveMode = 0;
    #1 check("R6 strobes off", {slvSelect, slvWrite, slvRead}, 3'b000);
    check("R2 oe back", padOe, 3'b111);
  endtask

  task automatic test_bus_gate();
    logic [2:0] v;
    @(negedge clk);
    busSel = 0; busWrite = 1; busAddr = 1; busWdata = 3'b101;
    @(negedge clk);
    busWrite = 0;
    readReg(1, v); check("R1 unselected write", v, 3'b000);
    writeReg(1, 3'b011);
    readReg(1, v); check("R1 dir readback", v, 3'b011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    test_reset();
    test_mixed_dir();
    test_latch_hidden();
    test_sync();
    test_analog();
    test_slave();
    test_bus_gate();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule